// File: doc/BRIEF.md
# Clock Reference Fallback Controller

This block decides which of two clock-control register sets, primary or secondary, drives the choice of reference source for a PLL. It contains a small byte-wide register bank on a simple read/write bus. It watches the error flags of a group of clock watchdog timers. When fallback is enabled and a trigger occurs, it moves to the secondary set and stays there until software clears it.

A trigger can come from three places. Software can issue a self-clearing force command. In normal hardware mode, a watchdog error counts only when that watchdog's bit is set in a programmable mask. In legacy hardware mode, the programmed mask is ignored, and the low bits of the main input selector decide which single watchdog may trigger. A status register shows the active set and whether the switch was caused by software or by hardware.

Top module: `clk_fallback_ctrl`

## Requirements
- R1: After reset, the primary set is active (`ref_sec_o`=0), `evt_hw_o`=0, and every register reads 0.
- R2: No switch happens while the enable field (offset 1, bits 3:0) is zero. Any nonzero value enables fallback. A force or a watchdog error with the field at zero leaves `ref_sec_o` at 0.
- R3: Writing 1 to bit 2 at offset 0 is a force. If fallback is enabled, `ref_sec_o` rises on the second rising edge after the write. Bit 2 reads 1 for exactly one cycle after the write and 0 after that.
- R4: When the type field (offset 1, bits 7:4) is zero, a switch happens on the first edge at which `wdog_err_i & mask` is nonzero. The mask bits 7:0 are at offset 2 and bits 15:8 are at offset 3.
- R5: When the type field is nonzero, offsets 2 and 3 are ignored. If `main_sel_i` is 0 to 5, only watchdog number `main_sel_i` can trigger. Values 6 and 7 allow no hardware trigger.
- R6: Once `ref_sec_o` is 1, it stays 1 until software writes 1 to bit 3 at offset 0. A clear takes effect on that edge and wins over a trigger on the same edge. Bit 3 always reads 0.
- R7: Offset 0 reads the active set in bit 0 and the source of the last switch in bit 1 (1 for hardware, 0 for software). This bit is also driven on `evt_hw_o`. The source is updated only when a switch occurs, and software wins when both sources trigger on the same edge.
- R8: Offsets 1, 2 and 3 read back the value last written. Offsets 4 to 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| wdog_err_i | input | 16 | Watchdog error levels, one bit per watchdog |
| main_sel_i | input | 3 | Low bits of the main input selector |
| ref_sec_o | output | 1 | 1 when the secondary clock register set is active |
| evt_hw_o | output | 1 | Source of the last switch, 1 for hardware |

## Verification
The hardest case to reach is two things landing on the same edge: a clear together with a live trigger, or a software force together with a hardware error. The bench gets there by holding a watchdog error level across the clear write. It also times a force write so that its pending bit coincides with a masked error one cycle later. It then steps the legacy selector through all eight values while the explicit mask is set to bits that must not fire. The run ends with a long stretch of random bus writes and error patterns, compared on every cycle against a behavioural model.

// File: rtl/clk_fb_pkg.sv
package clk_fb_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_MODE = 1;
  localparam int unsigned OFS_MASK = 2;
  localparam int unsigned BIT_ACT   = 0;
  localparam int unsigned BIT_SRC   = 1;
  localparam int unsigned BIT_FORCE = 2;
  localparam int unsigned BIT_CLEAR = 3;
endpackage

// File: rtl/fb_regs.sv
module fb_regs
  import clk_fb_pkg::*;
#(
  parameter int unsigned NUM_WD = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sec_i,
  input  logic              src_hw_i,
  output logic              en_o,
  output logic              legacy_o,
  output logic [NUM_WD-1:0] mask_o,
  output logic              force_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned MASK_BYTES = NUM_WD / DATA_W;

  logic [DATA_W-1:0] mode_q;
  logic [NUM_WD-1:0] mask_q;
  logic              force_q;
  logic              ctrl_wr;

  assign ctrl_wr = wr_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign clr_o   = ctrl_wr && wdata_i[BIT_CLEAR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      force_q <= 1'b0;
    end else begin
      force_q <= ctrl_wr && wdata_i[BIT_FORCE];
      if (wr_i && addr_i == ADDR_W'(OFS_MODE)) mode_q <= wdata_i;
    end
  end

  for (genvar b = 0; b < MASK_BYTES; b++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[b*DATA_W +: DATA_W] <= '0;
      else if (wr_i && addr_i == ADDR_W'(OFS_MASK + b))
        mask_q[b*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CTRL)) begin
      rdata_o[BIT_ACT]   = sec_i;
      rdata_o[BIT_SRC]   = src_hw_i;
      rdata_o[BIT_FORCE] = force_q;
    end else if (addr_i == ADDR_W'(OFS_MODE)) begin
      rdata_o = mode_q;
    end
    for (int b = 0; b < MASK_BYTES; b++)
      if (addr_i == ADDR_W'(OFS_MASK + b)) rdata_o = mask_q[b*DATA_W +: DATA_W];
  end

  assign en_o     = |mode_q[3:0];
  assign legacy_o = |mode_q[7:4];
  assign mask_o   = mask_q;
  assign force_o  = force_q;
endmodule

// File: rtl/fb_trigger.sv
module fb_trigger #(
  parameter int unsigned NUM_WD     = 16,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned LEGACY_MAX = 6
) (
  input  logic              en_i,
  input  logic              legacy_i,
  input  logic [NUM_WD-1:0] mask_i,
  input  logic [NUM_WD-1:0] err_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              force_i,
  output logic              ev_sw_o,
  output logic              ev_hw_o
);
  logic [NUM_WD-1:0] legacy_mask;
  logic [NUM_WD-1:0] eff_mask;

  // fixed selector decode: entry i enables watchdog i only
  for (genvar i = 0; i < NUM_WD; i++) begin : g_leg
    if (i < LEGACY_MAX) begin : g_on
      assign legacy_mask[i] = (sel_i == SEL_W'(i));
    end else begin : g_off
      assign legacy_mask[i] = 1'b0;
    end
  end

  assign eff_mask = legacy_i ? legacy_mask : mask_i;
  assign ev_hw_o  = en_i && |(err_i & eff_mask);
  assign ev_sw_o  = en_i && force_i;
endmodule

// File: rtl/fb_state.sv
module fb_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ev_sw_i,
  input  logic ev_hw_i,
  output logic sec_o,
  output logic src_hw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_o    <= 1'b0;
      src_hw_o <= 1'b0;
    end else if (clr_i) begin
      sec_o <= 1'b0;
    end else if (!sec_o && (ev_sw_i || ev_hw_i)) begin
      sec_o    <= 1'b1;
      src_hw_o <= !ev_sw_i;
    end
  end
endmodule

// File: rtl/clk_fallback_ctrl.sv
module clk_fallback_ctrl
  import clk_fb_pkg::*;
#(
  parameter int unsigned NUM_WD     = 16,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned LEGACY_MAX = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [NUM_WD-1:0] wdog_err_i,
  input  logic [SEL_W-1:0]  main_sel_i,
  output logic              ref_sec_o,
  output logic              evt_hw_o
);
  logic              fb_en, fb_legacy, force_q, clr, ev_sw, ev_hw, sec, src_hw;
  logic [NUM_WD-1:0] trig_mask;

  fb_regs #(.NUM_WD(NUM_WD)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .sec_i(sec), .src_hw_i(src_hw), .en_o(fb_en),
    .legacy_o(fb_legacy), .mask_o(trig_mask), .force_o(force_q), .clr_o(clr),
    .rdata_o(reg_rdata_o)
  );

  fb_trigger #(.NUM_WD(NUM_WD), .SEL_W(SEL_W), .LEGACY_MAX(LEGACY_MAX)) u_trig (
    .en_i(fb_en), .legacy_i(fb_legacy), .mask_i(trig_mask), .err_i(wdog_err_i),
    .sel_i(main_sel_i), .force_i(force_q), .ev_sw_o(ev_sw), .ev_hw_o(ev_hw)
  );

  fb_state u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .ev_sw_i(ev_sw),
    .ev_hw_i(ev_hw), .sec_o(sec), .src_hw_o(src_hw)
  );

  assign ref_sec_o = sec;
  assign evt_hw_o  = src_hw;
endmodule

// File: rtl/clk_fb_checker.sv
module clk_fb_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic [2:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic       ref_sec_o,
  input logic       evt_hw_o,
  input logic       force_q,
  input logic       fb_en
);
  logic clr_wr;
  assign clr_wr = reg_wr_i && reg_addr_i == 3'd0 && reg_wdata_i[3];

  a_r6_hold_until_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_sec_o && !clr_wr) |=> ref_sec_o);
  a_r6_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> !ref_sec_o);
  a_r2_switch_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_sec_o) |-> $past(fb_en));
  a_r3_force_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_q |=> !force_q);
  a_r7_source_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_sec_o && !$rose(ref_sec_o)) |-> $stable(evt_hw_o));
endmodule

bind clk_fallback_ctrl clk_fb_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .ref_sec_o(ref_sec_o), .evt_hw_o(evt_hw_o),
  .force_q(force_q), .fb_en(fb_en)
);

// File: tb/clk_fallback_ctrl_bench.sv
module clk_fallback_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [15:0] wdog_err_i = '0;
  logic [2:0]  main_sel_i = '0;
  logic        ref_sec_o, evt_hw_o;

  always #10 clk_i = ~clk_i;

  clk_fallback_ctrl u_clk_fallback_ctrl (.*);

  int n_vec = 0, n_bad = 0;
  logic [7:0] m_mode = 0, m_lo = 0, m_hi = 0;
  logic m_sec = 0, m_src = 0, m_frc = 0;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {5'd0, m_frc, m_src, m_sec};
      3'd1: return m_mode;
      3'd2: return m_lo;
      3'd3: return m_hi;
      default: return 8'd0;
    endcase
  endfunction

  task automatic m_step(bit w, logic [2:0] a, logic [7:0] d, logic [15:0] e, logic [2:0] s);
    bit en, leg, hw, sw, clr;
    logic [15:0] mask;
    en  = m_mode[3:0] != 0;
    leg = m_mode[7:4] != 0;
    if (leg) mask = (s < 6) ? (16'd1 << s) : 16'd0;
    else     mask = {m_hi, m_lo};
    hw  = en && ((e & mask) != 0);
    sw  = en && m_frc;
    clr = w && a == 0 && d[3];
    if (clr) m_sec = 0;
    else if (!m_sec && (sw || hw)) begin m_sec = 1; m_src = !sw; end
    m_frc = w && a == 0 && d[2];
    if (w && a == 1) m_mode = d;
    if (w && a == 2) m_lo = d;
    if (w && a == 3) m_hi = d;
  endtask

  task automatic cyc(string tag, bit w, logic [2:0] a, logic [7:0] d, logic [15:0] e, logic [2:0] s);
    reg_wr_i = w; reg_addr_i = a; reg_wdata_i = d; wdog_err_i = e; main_sel_i = s;
    #1 chk(tag, "rdata", reg_rdata_o, m_read(a));
    @(posedge clk_i);
    m_step(w, a, d, e, s);
    @(negedge clk_i);
    chk(tag, "ref_sec_o", ref_sec_o, m_sec);
    chk(tag, "evt_hw_o", evt_hw_o, m_src);
  endtask

  task automatic idle(string tag, logic [15:0] e, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 3'd0, 8'd0, e, 3'd0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", "ref_sec_o", ref_sec_o, 0);
    chk("R1", "evt_hw_o", evt_hw_o, 0);
    for (int a = 0; a < 8; a++) begin
      reg_addr_i = 3'(a);
      #1 chk("R1", "rdata", reg_rdata_o, 0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: disabled, nothing switches
    idle("R2", 16'hFFFF, 3);
    cyc("R2", 1, 3'd0, 8'h04, 16'h0, 0);
    idle("R2", 16'h0, 3);
    cyc("R2", 1, 3'd2, 8'hFF, 16'h0, 0);
    idle("R2", 16'hFFFF, 2);

    // R8: readback and unused offsets
    cyc("R8", 1, 3'd1, 8'h01, 16'h0, 0);
    cyc("R8", 1, 3'd2, 8'h10, 16'h0, 0);
    cyc("R8", 1, 3'd3, 8'h80, 16'h0, 0);
    for (int a = 4; a < 8; a++) cyc("R8", 1, 3'(a), 8'hFF, 16'h0, 0);
    for (int a = 0; a < 8; a++) cyc("R8", 0, 3'(a), 8'h00, 16'h0, 0);

    // R4: normal mask
    idle("R4", 16'h7F6F, 3);
    idle("R4", 16'h0010, 1);
    idle("R6", 16'h0, 3);
    cyc("R6", 1, 3'd0, 8'h08, 16'h8000, 0);
    idle("R6", 16'h8000, 2);
    cyc("R6", 1, 3'd0, 8'h08, 16'h0, 0);
    idle("R6", 16'h0, 2);

    // R3: force path
    cyc("R3", 1, 3'd0, 8'h04, 16'h0, 0);
    idle("R3", 16'h0, 3);
    cyc("R3", 1, 3'd0, 8'h08, 16'h0, 0);

    // R7: sw and hw on the same edge
    cyc("R7", 1, 3'd0, 8'h04, 16'h0, 0);
    idle("R7", 16'h0010, 2);
    cyc("R7", 1, 3'd0, 8'h08, 16'h0, 0);
    idle("R7", 16'h0, 1);

    // R5: legacy select ignores the explicit mask
    cyc("R5", 1, 3'd1, 8'h21, 16'h0, 0);
    for (int s = 0; s < 8; s++) begin
      cyc("R5", 0, 3'd0, 8'h0, 16'h8010 & ~(16'd1 << s), 3'(s));
      cyc("R5", 0, 3'd0, 8'h0, 16'd1 << s, 3'(s));
      cyc("R5", 1, 3'd0, 8'h08, 16'h0, 3'(s));
    end

    // random mix, R4 R5 R6 R7
    for (int i = 0; i < 4000; i++) begin
      bit w;
      logic [2:0] a;
      logic [7:0] d;
      logic [15:0] e;
      w = ($urandom % 4) == 0;
      a = 3'($urandom % 8);
      d = 8'($urandom);
      if (a == 0 && ($urandom % 3) != 0) d[3] = 1'b0;
      e = (($urandom % 4) == 0) ? 16'd1 << ($urandom % 16) : 16'h0;
      cyc("R4 R5 R6 R7 random", w, a, d, e, 3'($urandom % 8));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule